// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Generator

This block produces the switch commands for one phase of a cascaded H-bridge inverter built from `N_CELLS` cells, which gives `2*N_CELLS+1` output voltage levels. It derives `2*N_CELLS` triangular carriers from one shared phase counter. Each carrier occupies its own amplitude band, and the bands are stacked from the negative end of the signed reference range to the positive end. Every carrier is compared with a signed sine sample supplied by an upstream generator. The results set each cell to one of three states (+E, zero, -E), and each state drives four gate outputs per cell. Dead time is inserted between the two switches of each leg.

A two-bit scheme input selects how the carrier phases are arranged: all carriers in phase, carriers below zero inverted against those above zero, or every second carrier inverted. A new scheme is taken up only when a carrier period begins. The reference arrives on a valid/ready input. `ref_ready` is tied high, so the source never sees back-pressure. A sample is captured on every cycle in which `ref_valid` is high, and the last captured sample stays in force until the next one arrives.

Top module: `pwm_mc_gen`

## Requirements
- R1: Cell i (0-based) compares against an upper carrier in band `N_CELLS+i` and a lower carrier in band `N_CELLS-1-i`, with bands numbered from 0 at the most negative end. The cell is +E when the reference is strictly greater than its upper carrier, -E when it is strictly less than its lower carrier, and zero otherwise.
- R2: Each band is `2^REF_W/(2*N_CELLS)` codes wide. The phase counter resets to 0 and advances by one every clock. A carrier period is `2*band` clocks. Within a period the un-inverted carrier offset equals the phase for the first half and falls back to 0 during the second half. With scheme 0, every carrier uses the un-inverted offset.
- R3: With scheme 1, the carriers of the bands below zero (bands 0 to `N_CELLS-1`) use the inverted offset `band-1-offset`, and the bands above zero use the plain offset.
- R4: With scheme 2, carriers in odd-numbered bands use the inverted offset and carriers in even-numbered bands use the plain offset.
- R5: A value on `mode` takes effect only at the clock edge where the phase counter wraps from its maximum to 0. For the rest of the period, the scheme in force at the period's start stays in use. Reset selects scheme 0.
- R6: The gate bits of cell i are at `gate[4i+0]` (left upper), `[4i+1]` (left lower), `[4i+2]` (right upper) and `[4i+3]` (right lower). +E drives left upper and right lower. -E drives right upper and left lower. Zero drives both upper switches.
- R7: The upper and lower switch of a leg are never on together. When a leg changes over, both of its switches stay off for exactly `dead_cycles+1` clock cycles.
- R8: While `rst_n` is low, all gate outputs are 0. After release, a leg stays off for `dead_cycles+1` cycles before it first turns on.
- R9: `ref_ready` is always 1. `ref_data` is captured on a clock edge only when `ref_valid` is high. Data presented while `ref_valid` is low has no effect.
- R10: Scheme code 3 behaves as scheme 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Carrier scheme: 0 in phase, 1 opposed about zero, 2 alternating, 3 as 0 |
| dead_cycles | input | DT_W | Dead time setting; the off gap lasts this value plus one cycle |
| ref_valid | input | 1 | Reference sample valid |
| ref_ready | output | 1 | Always 1 |
| ref_data | input | REF_W | Signed reference sample |
| gate | output | 4*N_CELLS | Switch commands, four per cell |

## Verification
The hardest case to reach from the ports is a scheme change that arrives part way through a carrier period. It must not alter the carriers until the counter wraps. The bench keeps its own copy of the phase, derived from reset and the clock count. It changes `mode` in the middle of a period and checks that the old arrangement still holds later in that same period and that the new one holds in the next period. Reference values are placed in the middle of a band, and samples are taken at phases far from the crossing points, so that each reading shows one carrier's position without ambiguity.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    SCH_PD   = 2'd0,
    SCH_POD  = 2'd1,
    SCH_APOD = 2'd2,
    SCH_RSVD = 2'd3
  } sch_e;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'd0,
    LVL_POS  = 2'd1,
    LVL_NEG  = 2'd2
  } lvl_e;
endpackage

// File: rtl/pwm_carrier_gen.sv
module pwm_carrier_gen
  import pwm_pkg::*;
#(
  parameter int N_CELLS = 2,
  parameter int REF_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  sch_e                    mode_in,
  output logic signed [REF_W-1:0] car [2*N_CELLS]
);
  localparam int NCAR   = 2 * N_CELLS;
  localparam int BAND_W = REF_W - $clog2(NCAR);

  logic [BAND_W:0]   ph;
  logic              wrap;
  logic [BAND_W-1:0] off_up, off_dn;
  sch_e              sch_q;

  assign wrap = &ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      sch_q <= SCH_PD;
    end else begin
      ph <= ph + 1'b1;
      if (wrap) sch_q <= mode_in;
    end
  end

  // triangle: rises in first half of the period, falls in the second
  assign off_up = ph[BAND_W] ? ~ph[BAND_W-1:0] : ph[BAND_W-1:0];
  assign off_dn = ~off_up;

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    localparam logic signed [REF_W:0] BASE =
      (REF_W+1)'(k * (2 ** BAND_W) - 2 ** (REF_W - 1));
    logic              flip;
    logic [REF_W:0]    off;
    logic signed [REF_W:0] sum;

    always_comb begin
      case (sch_q)
        SCH_POD:  flip = (k < N_CELLS);
        SCH_APOD: flip = (k % 2 == 1);
        default:  flip = 1'b0;
      endcase
    end

    assign off    = (REF_W+1)'(flip ? off_dn : off_up);
    assign sum    = BASE + $signed(off);
    assign car[k] = sum[REF_W-1:0];
  end

  // R5: scheme only changes across the period boundary
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(sch_q));
endmodule

// File: rtl/pwm_cell_cmp.sv
module pwm_cell_cmp
  import pwm_pkg::*;
#(
  parameter int REF_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_s,
  input  logic signed [REF_W-1:0] car_hi,
  input  logic signed [REF_W-1:0] car_lo,
  output lvl_e                    lvl
);
  logic over_hi, under_lo;

  assign over_hi  = ref_s > car_hi;
  assign under_lo = ref_s < car_lo;
  assign lvl      = over_hi ? LVL_POS : (under_lo ? LVL_NEG : LVL_ZERO);

  // R1: the upper band carrier always sits above the lower band carrier
  p_band_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    car_hi > car_lo);
  p_lvl_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(over_hi && under_lo));
endmodule

// File: rtl/pwm_leg_dt.sv
module pwm_leg_dt #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want_up,
  input  logic [DT_W-1:0] dead,
  output logic            sw_up,
  output logic            sw_dn
);
  logic [DT_W-1:0] cnt;
  logic            on_ok;

  assign on_ok = want_up ? sw_up : sw_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_up <= 1'b0;
      sw_dn <= 1'b0;
      cnt   <= '0;
    end else if (on_ok) begin
      cnt <= '0;
    end else if (sw_up || sw_dn) begin
      sw_up <= 1'b0;
      sw_dn <= 1'b0;
      cnt   <= '0;
    end else if (cnt >= dead) begin
      sw_up <= want_up;
      sw_dn <= !want_up;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_leg_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_up && sw_dn));
  p_up_after_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_up) |-> $past(!sw_dn));
  p_dn_after_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_dn) |-> $past(!sw_up));
endmodule

// File: rtl/pwm_mc_gen.sv
module pwm_mc_gen
  import pwm_pkg::*;
#(
  parameter int N_CELLS = 2,
  parameter int REF_W   = 8,
  parameter int DT_W    = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode,
  input  logic [DT_W-1:0]         dead_cycles,
  input  logic                    ref_valid,
  output logic                    ref_ready,
  input  logic signed [REF_W-1:0] ref_data,
  output logic [4*N_CELLS-1:0]    gate
);
  localparam int NCAR = 2 * N_CELLS;

  logic signed [REF_W-1:0] ref_q;
  logic signed [REF_W-1:0] car [NCAR];

  assign ref_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ref_q <= '0;
    else if (ref_valid) ref_q <= ref_data;
  end

  pwm_carrier_gen #(.N_CELLS(N_CELLS), .REF_W(REF_W)) u_car (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_in (sch_e'(mode)),
    .car     (car)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    lvl_e lvl;

    pwm_cell_cmp #(.REF_W(REF_W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_s  (ref_q),
      .car_hi (car[N_CELLS+i]),
      .car_lo (car[N_CELLS-1-i]),
      .lvl    (lvl)
    );

    pwm_leg_dt #(.DT_W(DT_W)) u_left (
      .clk     (clk),
      .rst_n   (rst_n),
      .want_up (lvl != LVL_NEG),
      .dead    (dead_cycles),
      .sw_up   (gate[4*i+0]),
      .sw_dn   (gate[4*i+1])
    );

    pwm_leg_dt #(.DT_W(DT_W)) u_right (
      .clk     (clk),
      .rst_n   (rst_n),
      .want_up (lvl != LVL_POS),
      .dead    (dead_cycles),
      .sw_up   (gate[4*i+2]),
      .sw_dn   (gate[4*i+3])
    );
  end

  // R9: the held sample moves only on a valid beat
  p_ref_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> $stable(ref_q));
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready);
endmodule

// File: tb/tb_pwm_mc_gen.sv
`timescale 1ns/1ps
module tb_pwm_mc_gen;
  localparam int NC = 2;
  localparam int RW = 8;
  localparam int DW = 6;
  localparam int Z = 0, P = 1, N = 2;
  localparam int NV = 16;

  // vector columns: scheme, reference, phase at sample, cell0, cell1
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 1, 1, 1, 2, 2, 2, 2, 3, 0, 0, 1, 2};
  localparam int V_REF  [NV] = '{32, 32, -32, -32, -32, -32, 96, 96, 96, -32, 32, -32, -96, -96, -96, -96};
  localparam int V_PH   [NV] = '{8, 48, 8, 48, 8, 48, 8, 8, 48, 8, 8, 8, 8, 48, 8, 8};
  localparam int V_C0   [NV] = '{P, Z, Z, N, N, Z, P, P, P, N, P, Z, N, N, N, N};
  localparam int V_C1   [NV] = '{Z, Z, Z, Z, Z, Z, P, Z, P, Z, Z, Z, Z, N, N, Z};
  localparam string V_REQ [NV] = '{"R2", "R2", "R2", "R1", "R3", "R3", "R3", "R4", "R4",
                                   "R4", "R4", "R10", "R1", "R1", "R3", "R4"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [DW-1:0] dead_cycles = 6'd2;
  logic ref_valid = 1'b0;
  logic ref_ready;
  logic signed [RW-1:0] ref_data = '0;
  logic [4*NC-1:0] gate;

  int checks = 0;
  int errors = 0;
  logic [6:0] bp;

  always #5 clk = ~clk;

  pwm_mc_gen #(.N_CELLS(NC), .REF_W(RW), .DT_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dead_cycles(dead_cycles),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_data(ref_data), .gate(gate)
  );

  // phase as stated in R2: zero at reset, one step per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bp <= '0;
    else        bp <= bp + 7'd1;
  end

  function automatic int cell_state(input int c);
    logic [3:0] g;
    g = gate[4*c +: 4];
    case (g)
      4'b0101: return Z;
      4'b1001: return P;
      4'b0110: return N;
      default: return 9;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_phase(input int p);
    do @(negedge clk); while (bp != 7'(p));
  endtask

  task automatic send_ref(input int v);
    @(negedge clk);
    ref_data  = RW'(v);
    ref_valid = 1'b1;
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic gap_len(input int bit_off, input int bit_on, output int n);
    n = 0;
    while (gate[bit_off] == 1'b1) @(negedge clk);
    while (gate[bit_on] == 1'b0 && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    check("R8", int'(gate), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", int'(gate), 0);

    for (int v = 0; v < NV; v++) begin
      mode = 2'(V_MODE[v]);
      send_ref(V_REF[v]);
      wait_phase(127);
      wait_phase(V_PH[v]);
      check(V_REQ[v], cell_state(0), V_C0[v]);
      check(V_REQ[v], cell_state(1), V_C1[v]);
    end

    // R5: scheme change in mid-period waits for the wrap
    mode = 2'd0;
    send_ref(-32);
    wait_phase(127);
    wait_phase(20);
    mode = 2'd1;
    wait_phase(48);
    check("R5", cell_state(0), N);
    wait_phase(127);
    wait_phase(48);
    check("R5", cell_state(0), Z);

    // R9: data without valid is ignored
    mode = 2'd0;
    send_ref(32);
    @(negedge clk);
    ref_data = 8'sd96;
    check("R9", int'(ref_ready), 1);
    wait_phase(127);
    wait_phase(48);
    check("R9", cell_state(0), Z);

    // R7: dead time gap on the right leg of cell 0 when +E turns to zero
    dead_cycles = 6'd5;
    wait_phase(127);
    wait_phase(20);
    gap_len(3, 2, gap);
    check("R7", gap, 6);
    dead_cycles = 6'd0;
    wait_phase(127);
    wait_phase(20);
    gap_len(3, 2, gap);
    check("R7", gap, 1);
    check("R6", cell_state(0), Z);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule